// File: doc/BRIEF.md
# Registered Command Buffer with Timed Activation

This block is the address and control register of a registered memory module. On every clock edge it captures an address/command word and the clock-enable bit. One cycle later it drives them to the memory devices, so a command reaches the devices one clock after the system issues it. An active-low asynchronous clear forces every output, clock-enable included, to zero at once. The clear does not wait for the clock and does not depend on the data inputs.

Releasing the clear does not restore capture straight away. The release first passes through a two-stage synchronizer. It then starts an activation counter of `ACT_CYCLES` clocks. Until that count completes, all outputs are held low, so the memory devices keep seeing a low clock-enable. A `ready` output rises when the activation window ends. The first input sampled after that is passed through on the following edge. `DATA_W` sets the width of the address/command bus.

Top module: `cmd_regbuf`

## Requirements
- R1: Driving `rst_n` low clears `bus_out`, `cke_out` and `ready` to 0 at once, before any further clock edge.
- R2: While `rst_n` stays low, neither clock edges nor changes on `bus_in` and `cke_in` move any output away from 0.
- R3: After `rst_n` rises, the first clock edge only loads the first synchronizer stage. The second edge makes the release visible. `ready` is still 0 after edge number `ACT_CYCLES+1` counted from the release.
- R4: `ready` becomes 1 right after edge number `ACT_CYCLES+2` following the release. It stays 1 until `rst_n` goes low again.
- R5: Whenever `ready` was 0 before a clock edge, that edge leaves `bus_out` and `cke_out` at 0, even when `cke_in` is 1 and `bus_in` is nonzero.
- R6: When `ready` was 1 before an edge, that edge loads `bus_in` into `bus_out` and `cke_in` into `cke_out`. This gives one cycle of latency. The first value passed through is the input present at the first edge after `ready` rose.
- R7: A reset asserted in the middle of operation restarts the whole sequence: synchronization, the full activation window, and then capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low clear; asserted and released asynchronously |
| bus_in | input | DATA_W | Address/command word from the system |
| cke_in | input | 1 | Clock-enable from the system |
| bus_out | output | DATA_W | Registered address/command to the memory devices |
| cke_out | output | 1 | Registered clock-enable to the memory devices |
| ready | output | 1 | Activation window has elapsed and capture is live |

## Verification
The hardest situation to reach is a clear that arrives while the buffer is driving nonzero values. The check must show the outputs dropping between two clock edges, not at the next edge. To set this up, the stimulus forces `bus_in` to all ones and `cke_in` high for one cycle once `ready` is up. It then pulls `rst_n` low two time units after a rising edge and samples the outputs one time unit later, with no clock edge in between. The release edges are also placed away from the clock. This checks that activation is counted from the synchronized release and not from the raw pin.

// File: rtl/cmd_regbuf_pkg.sv
// Package: shared helpers for the registered command buffer.
// Assumes: counts passed to cnt_w are non-negative.
package cmd_regbuf_pkg;

    // Width of a counter that must hold values 0..n, at least one bit.
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cmd_regbuf_rsync.sv
// Module: reset-release synchronizer.
// Assertion of rst_n clears both stages at once. Release reaches rel_ok
// only after two rising clock edges. Assumes clk runs while the release occurs.
module cmd_regbuf_rsync (
    input  logic clk,
    input  logic rst_n,
    output logic rel_ok
);
    logic stage1;
    logic stage2;

    // Two-flop chain: clear asynchronously, shift a one in synchronously.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            stage2 <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            stage2 <= stage1;
        end
    end

    assign rel_ok = stage2;
endmodule

// File: rtl/cmd_regbuf_act.sv
// Module: activation timer.
// Counts clock edges after the synchronized release and raises live when
// ACT_CYCLES have elapsed. Assumes ACT_CYCLES >= 1. The count saturates, so
// live stays high until rst_n clears the counter.
module cmd_regbuf_act
    import cmd_regbuf_pkg::*;
#(
    parameter int ACT_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rel_ok,
    output logic live
);
    localparam int CW = cnt_w(ACT_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(ACT_CYCLES);

    logic [CW-1:0] elapsed;

    // Saturating count of edges that saw the synchronized release.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (rel_ok && (elapsed != LAST)) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // Window ends once the count has reached its limit.
    assign live = rel_ok && (elapsed == LAST);
endmodule

// File: rtl/cmd_regbuf_cap.sv
// Module: capture register lane set.
// Each lane is a flop with an asynchronous clear. It loads its input when
// pass is high and zero otherwise. Assumes W >= 1.
module cmd_regbuf_cap #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_lane
        // One lane: async clear, then gated capture on each edge.
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= pass ? d[i] : 1'b0;
            end
        end
    end
endmodule

// File: rtl/cmd_regbuf.sv
// Module: registered command buffer (top).
// Holds every output low during an asynchronous clear and for a timed
// activation window after release. After that it delays the command word and
// clock-enable by one clock. Assumes ACT_CYCLES >= 1 and DATA_W >= 1.
module cmd_regbuf #(
    parameter int DATA_W     = 24,
    parameter int ACT_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_in,
    input  logic              cke_in,
    output logic [DATA_W-1:0] bus_out,
    output logic              cke_out,
    output logic              ready
);
    localparam int LANES = DATA_W + 1;

    logic             rel_ok;
    logic             live;
    logic [LANES-1:0] lanes_d;
    logic [LANES-1:0] lanes_q;

    cmd_regbuf_rsync u_rsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rel_ok (rel_ok)
    );

    cmd_regbuf_act #(.ACT_CYCLES(ACT_CYCLES)) u_act (
        .clk    (clk),
        .rst_n  (rst_n),
        .rel_ok (rel_ok),
        .live   (live)
    );

    // Clock-enable rides in the top lane beside the command word.
    assign lanes_d = {cke_in, bus_in};

    cmd_regbuf_cap #(.W(LANES)) u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .pass  (live),
        .d     (lanes_d),
        .q     (lanes_q)
    );

    assign bus_out = lanes_q[DATA_W-1:0];
    assign cke_out = lanes_q[DATA_W];
    assign ready   = live;
endmodule

// File: rtl/cmd_regbuf_chk.sv
// Module: property checker for cmd_regbuf, attached by bind.
// Counts edges since release on its own and relates the port behaviour to it.
module cmd_regbuf_chk #(
    parameter int DATA_W     = 24,
    parameter int ACT_CYCLES = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] bus_in,
    input logic              cke_in,
    input logic [DATA_W-1:0] bus_out,
    input logic              cke_out,
    input logic              ready
);
    localparam int SAT = ACT_CYCLES + 3;

    int edges;

    // Edges seen since the last release, saturating.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) edges <= 0;
        else if (edges < SAT) edges <= edges + 1;
    end

    // R1
    cleared_in_reset_chk: assert property (@(posedge clk) disable iff (rst_n)
        (bus_out == '0) && !cke_out && !ready);

    // R4
    ready_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (edges >= ACT_CYCLES + 2));

    // R4
    ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> ready);

    // R5
    held_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |=> (bus_out == '0) && !cke_out);

    // R6
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> (bus_out == $past(bus_in)) && (cke_out == $past(cke_in)));
endmodule

bind cmd_regbuf cmd_regbuf_chk #(.DATA_W(DATA_W), .ACT_CYCLES(ACT_CYCLES)) u_chk (.*);

// File: tb/tb_cmd_regbuf.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module tb_cmd_regbuf;
    localparam int W   = 24;
    localparam int ACT = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] bus_in = '0;
    logic         cke_in = 1'b0;
    logic [W-1:0] bus_out;
    logic         cke_out;
    logic         ready;

    int checks = 0;
    int fails  = 0;
    bit second_run = 0;

    cmd_regbuf #(.DATA_W(W), .ACT_CYCLES(ACT)) dut (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .cke_in(cke_in),
        .bus_out(bus_out), .cke_out(cke_out), .ready(ready)
    );

    always #5 clk = ~clk;

    // Reference model: edge count since release, expected outputs.
    int           n;
    logic         m_ready;
    logic [W-1:0] m_bus;
    logic         m_cke;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n = 0; m_ready = 0; m_bus = '0; m_cke = 0;
        end else begin
            if (m_ready) begin m_bus = bus_in; m_cke = cke_in; end
            else begin m_bus = '0; m_cke = 0; end
            n = n + 1;
            m_ready = (n >= ACT + 2);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Compare all outputs to the model at the falling edge.
    task automatic compare();
        string rq;
        if (!rst_n) rq = "R2";
        else if (second_run) rq = "R7";
        else if (n <= ACT + 1) rq = "R3";
        else rq = "R4";
        check(rq, 64'(ready), 64'(m_ready));
        if (!rst_n) rq = "R2";
        else if (second_run) rq = "R7";
        else if (m_ready && n > ACT + 2) rq = "R6";
        else rq = "R5";
        check(rq, 64'(bus_out), 64'(m_bus));
        check(rq, 64'(cke_out), 64'(m_cke));
    endtask

    task automatic step(input bit force_cke);
        @(negedge clk);
        compare();
        bus_in = W'($urandom);
        cke_in = force_cke ? 1'b1 : 1'($urandom);
    endtask

    initial begin
        // Reset state and inactivity while held low (R2)
        for (int i = 0; i < 4; i++) step(0);
        // Release away from the clock edge; cke_in forced high in window (R3, R5)
        #2 rst_n = 1'b1;
        for (int i = 0; i < ACT + 2; i++) step(1);
        // Explicit R3/R4 boundary: ready rose after edge ACT+2
        check("R4", 64'(ready), 64'(1));
        for (int i = 0; i < 40; i++) step(0);
        // Drive all ones so the outputs are nonzero before the clear
        @(negedge clk);
        compare();
        bus_in = '1; cke_in = 1'b1;
        @(posedge clk);
        #2;
        check("R6", 64'(bus_out), 64'({W{1'b1}}));
        rst_n = 1'b0;
        #1;
        // R1: cleared with no clock edge in between
        check("R1", 64'(bus_out), 64'(0));
        check("R1", 64'(cke_out), 64'(0));
        check("R1", 64'(ready), 64'(0));
        for (int i = 0; i < 3; i++) step(1);
        // R7: second full sequence
        second_run = 1;
        #3 rst_n = 1'b1;
        for (int i = 0; i < ACT + 12; i++) step(0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule